// File: doc/BRIEF.md
# Egress VLAN Tag Insertion Unit

This block sits at the egress side of a switch port group. It decides, frame by frame, whether an 802.1Q tag is added. It also performs the insertion on an 8-bit byte stream. Each egress port has its own small configuration entry, written through a simple write strobe:

- a tag mode,
- a native (port) VLAN ID,
- a TPID select.

The decision uses the egress port number and the frame's classified VLAN ID, both presented alongside the first byte of the frame. It yields an insert flag and the 32-bit tag word. Both are visible at the ports at all times for the current `in_port`/`in_vid`.

The stream side copies the frame through with one cycle of latency. When a tag is due, the four tag bytes go out immediately after the twelve address bytes (destination and source MAC), most significant byte first. The input is held off with `in_ready` low for exactly those four cycles. Priority remapping and double tagging are not part of this block.

Top module: `egress_tag_unit`

## Requirements
- R1: After reset every port entry holds tag mode 0, port VID 0 and TPID select 0, `out_valid` is 0, `in_ready` is 1, and `dec_insert` is 0 for any port and VID.
- R2: Tag modes 0 and 2 never insert; the frame leaves unchanged, each accepted byte appearing on `out_data` one clock after it is accepted, with `in_last` carried to `out_last`.
- R3: Tag mode 3 inserts a tag into every frame regardless of the classified VID.
- R4: Tag mode 1 inserts a tag unless the classified VID equals the port's configured VID, in which case the frame leaves untagged.
- R5: The tag word is {TPID[15:0], 4'b0000, VID[11:0]}, where VID is the classified VID; TPID select 0 gives 0x8100 and TPID select 1 gives the parameter `ALT_TPID` (default 0x88A8).
- R6: An inserted tag appears as four bytes, bits 31:24 first and bits 7:0 last, right after the 12th frame byte, followed by the rest of the frame.
- R7: While a tag is being emitted `in_ready` is low for exactly four consecutive cycles and `out_valid` stays high; frames without insertion see `in_ready` always high.
- R8: A frame whose last byte is among its first 12 bytes is never tagged, whatever the decision.
- R9: The decision for a frame is taken from `in_port`, `in_vid` and the configuration at its first accepted byte; configuration writes during the frame do not change it.
- R10: A configuration write (`cfg_we`) updates only the addressed port's entry and is used by the decision from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one port entry |
| cfg_port | input | 3 | Port whose entry is written |
| cfg_mode | input | 2 | Tag mode: 0 untagged, 1 all but native VID, 2 as 0, 3 all |
| cfg_tpid_sel | input | 1 | TPID select: 0 = 0x8100, 1 = ALT_TPID |
| cfg_vid | input | 12 | Port (native) VID |
| in_port | input | 3 | Egress port of the frame, valid with its first byte |
| in_vid | input | 12 | Classified VID, valid with first byte |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of output frame |
| dec_insert | output | 1 | Insert decision for current in_port/in_vid |
| dec_tag | output | 32 | Tag word for current in_port/in_vid |

## Verification
The decision outputs are combinational from `in_port`, `in_vid` and the stored entries, so they are checked in the same cycle as the inputs change. The exception is a configuration write, whose effect is checked one clock later. A frame byte accepted at one edge is due on `out_data` after that edge. A tag starts right after the 12th byte, and the remainder follows after four tag cycles. The bench therefore collects every valid output byte at the falling edge and compares the whole sequence with an expected frame built from the requirements. It counts `in_ready` low cycles at the falling edge while the frame is being sent.

// File: rtl/egress_tag_pkg.sv
package egress_tag_pkg;

    localparam int VID_W = 12;

    typedef enum logic [1:0] {
        MODE_UNTAGGED = 2'd0,
        MODE_NATIVE   = 2'd1,
        MODE_RSVD     = 2'd2,
        MODE_ALL      = 2'd3
    } tag_mode_e;

    typedef struct packed {
        tag_mode_e        mode;
        logic             tpid_sel;
        logic [VID_W-1:0] vid;
    } port_cfg_t;

    typedef enum logic {
        PH_PASS = 1'b0,
        PH_TAG  = 1'b1
    } ins_phase_e;

    function automatic logic [15:0] tpid_of(input logic sel, input logic [15:0] alt);
        return sel ? alt : 16'h8100;
    endfunction

endpackage

// File: rtl/egress_tag_cfg.sv
module egress_tag_cfg
    import egress_tag_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_port,
    input  port_cfg_t        wr_data,
    input  logic [PW-1:0]    rd_port,
    output port_cfg_t        rd_data
);

    port_cfg_t entry_q [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_cfg_t entry_d;

        always_comb begin
            entry_d = entry_q[p];
            if (wr_en && (wr_port == PW'(p))) begin
                entry_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[p] <= '{mode: MODE_UNTAGGED, tpid_sel: 1'b0, vid: '0};
            end else begin
                entry_q[p] <= entry_d;
            end
        end
    end

    always_comb begin
        rd_data = entry_q[0];
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == PW'(p)) begin
                rd_data = entry_q[p];
            end
        end
    end

endmodule

// File: rtl/egress_tag_decide.sv
module egress_tag_decide
    import egress_tag_pkg::*;
#(
    parameter logic [15:0] ALT_TPID = 16'h88A8
) (
    input  port_cfg_t        cfg,
    input  logic [VID_W-1:0] vid,
    output logic             insert,
    output logic [31:0]      tag
);

    always_comb begin
        unique case (cfg.mode)
            MODE_ALL:    insert = 1'b1;
            MODE_NATIVE: insert = (vid != cfg.vid);
            default:     insert = 1'b0;
        endcase
        tag = {tpid_of(cfg.tpid_sel, ALT_TPID), 4'b0000, vid};
    end

endmodule

// File: rtl/egress_tag_inserter.sv
module egress_tag_inserter
    import egress_tag_pkg::*;
#(
    parameter int HDR_BYTES = 12,
    localparam int CW = $clog2(HDR_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    input  logic        dec_insert,
    input  logic [31:0] dec_tag,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last
);

    typedef struct packed {
        ins_phase_e  phase;
        logic [1:0]  k;
        logic [CW-1:0] cnt;
        logic        sof;
        logic        ins;
        logic [31:0] tag;
        logic        ov;
        logic [7:0]  od;
        logic        ol;
    } ins_st_t;

    ins_st_t st_d, st_q;
    logic    accept;
    logic    ins_eff;

    assign in_ready  = (st_q.phase == PH_PASS);
    assign accept    = in_valid && in_ready;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_last  = st_q.ol;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.ol = 1'b0;
        ins_eff = st_q.sof ? dec_insert : st_q.ins;
        if (st_q.phase == PH_TAG) begin
            st_d.ov = 1'b1;
            unique case (st_q.k)
                2'd0:    st_d.od = st_q.tag[31:24];
                2'd1:    st_d.od = st_q.tag[23:16];
                2'd2:    st_d.od = st_q.tag[15:8];
                default: st_d.od = st_q.tag[7:0];
            endcase
            st_d.k = st_q.k + 2'd1;
            if (st_q.k == 2'd3) begin
                st_d.phase = PH_PASS;
            end
        end else if (accept) begin
            st_d.ov  = 1'b1;
            st_d.od  = in_data;
            st_d.ol  = in_last;
            st_d.sof = in_last;
            if (st_q.sof) begin
                st_d.ins = dec_insert;
                st_d.tag = dec_tag;
            end
            if (in_last) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CW'(HDR_BYTES)) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            if ((st_q.cnt == CW'(HDR_BYTES - 1)) && ins_eff && !in_last) begin
                st_d.phase = PH_TAG;
                st_d.k     = 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_PASS, k: '0, cnt: '0, sof: 1'b1, ins: 1'b0,
                      tag: '0, ov: 1'b0, od: '0, ol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_TAG_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> (out_valid && !out_last)); // R6
    AST_HOLD_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (!$past(in_ready, 2) && !$past(in_ready, 3) && !$past(in_ready, 4))); // R7
    AST_TAG_STREAM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> out_valid); // R7
    AST_TAG_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !out_last); // R8

endmodule

// File: rtl/egress_tag_unit.sv
module egress_tag_unit
    import egress_tag_pkg::*;
#(
    parameter int          NUM_PORTS = 8,
    parameter int          HDR_BYTES = 12,
    parameter logic [15:0] ALT_TPID  = 16'h88A8,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PW-1:0]    cfg_port,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_tpid_sel,
    input  logic [VID_W-1:0] cfg_vid,
    input  logic [PW-1:0]    in_port,
    input  logic [VID_W-1:0] in_vid,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             dec_insert,
    output logic [31:0]      dec_tag
);

    port_cfg_t wr_entry;
    port_cfg_t sel_entry;

    assign wr_entry = '{mode: tag_mode_e'(cfg_mode), tpid_sel: cfg_tpid_sel, vid: cfg_vid};

    egress_tag_cfg #(.NUM_PORTS(NUM_PORTS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_port (cfg_port),
        .wr_data (wr_entry),
        .rd_port (in_port),
        .rd_data (sel_entry)
    );

    egress_tag_decide #(.ALT_TPID(ALT_TPID)) u_decide (
        .cfg    (sel_entry),
        .vid    (in_vid),
        .insert (dec_insert),
        .tag    (dec_tag)
    );

    egress_tag_inserter #(.HDR_BYTES(HDR_BYTES)) u_ins (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .dec_insert (dec_insert),
        .dec_tag    (dec_tag),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last)
    );

    AST_TAG_CARRIES_VID: assert property (@(posedge clk) disable iff (!rst_n)
        dec_insert |-> (dec_tag[11:0] == in_vid && dec_tag[15:12] == 4'b0)); // R5
    AST_STD_TPID: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_entry.tpid_sel) |-> (dec_tag[31:16] == 16'h8100)); // R5
    AST_NATIVE_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_entry.mode == MODE_NATIVE && sel_entry.vid == in_vid) |-> !dec_insert); // R4

endmodule

// File: tb/egress_tag_unit_tb.sv
module egress_tag_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_port = '0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_tpid_sel = 1'b0;
    logic [11:0] cfg_vid = '0;
    logic [2:0]  in_port = '0;
    logic [11:0] in_vid = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready, out_valid, out_last, dec_insert;
    logic [7:0]  out_data;
    logic [31:0] dec_tag;

    int tests = 0;
    int fails = 0;
    logic [8:0] got[$];
    logic       mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    egress_tag_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_mode(cfg_mode),
        .cfg_tpid_sel(cfg_tpid_sel), .cfg_vid(cfg_vid),
        .in_port(in_port), .in_vid(in_vid),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .dec_insert(dec_insert), .dec_tag(dec_tag)
    );

    always @(negedge clk) begin
        if (mon_en && out_valid) got.push_back({out_last, out_data});
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] p, input logic [1:0] m, input logic t, input logic [11:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = p; cfg_mode = m; cfg_tpid_sel = t; cfg_vid = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Sends a frame of len bytes; optionally rewrites cfg of port p at byte chg_at to mode 0.
    // Compares the whole output with the expected frame and the in_ready low count.
    task automatic run_frame(input string req, input logic [2:0] p, input logic [11:0] vid,
                             input int len, input bit exp_ins, input logic [31:0] exp_tag,
                             input int chg_at);
        logic [8:0] exp_q[$];
        int lows = 0;
        bit bad = 0;
        got.delete();
        for (int i = 0; i < len; i++) begin
            if (i == 12 && exp_ins) begin
                for (int b = 3; b >= 0; b--) exp_q.push_back({1'b0, exp_tag[8*b +: 8]});
            end
            exp_q.push_back({(i == len - 1), 8'(8'h30 + i)});
        end
        mon_en = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'(8'h30 + i); in_last = (i == len - 1);
            in_port = (i == 0) ? p : 3'd7; in_vid = (i == 0) ? vid : 12'hFFF;
            if (i == chg_at) begin
                cfg_we = 1'b1; cfg_port = p; cfg_mode = 2'd0; cfg_tpid_sel = 1'b0; cfg_vid = vid;
            end
            while (!in_ready) begin
                lows++;
                @(negedge clk);
            end
            @(posedge clk);
            #1 cfg_we = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (6) @(negedge clk);
        mon_en = 1'b0;
        if (got.size() != exp_q.size()) bad = 1;
        else foreach (exp_q[j]) if (got[j] !== exp_q[j]) bad = 1;
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s frame len actual=%0d expected=%0d first actual=%0h expected=%0h",
                     req, got.size(), exp_q.size(),
                     (got.size() > 12) ? got[12] : 9'h0, exp_q[(exp_q.size() > 12) ? 12 : 0]);
        end
        check({req, " in_ready low cycles (R7)"}, 64'(lows), exp_ins ? 64'd4 : 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 in_ready", 64'(in_ready), 64'd1);
        check("R1 out_valid", 64'(out_valid), 64'd0);
        for (int p = 0; p < 8; p++) begin
            in_port = 3'(p); in_vid = 12'd0;
            #1 check("R1 dec_insert reset entry", 64'(dec_insert), 64'd0);
        end
    endtask

    task automatic t_latency;
        @(negedge clk);
        in_port = 3'd0; in_vid = 12'd9;
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R2 one-cycle out_valid", 64'(out_valid), 64'd1);
        check("R2 one-cycle out_data", 64'({out_last, out_data}), 64'h1A5);
        @(negedge clk);
        check("R2 out idle after", 64'(out_valid), 64'd0);
    endtask

    task automatic t_modes;
        write_cfg(3'd0, 2'd0, 1'b0, 12'd0);
        run_frame("R2 mode0", 3'd0, 12'd10, 20, 0, 32'h0, -1);
        write_cfg(3'd1, 2'd2, 1'b0, 12'd0);
        run_frame("R2 mode2 reserved", 3'd1, 12'd10, 20, 0, 32'h0, -1);
        write_cfg(3'd1, 2'd3, 1'b1, 12'd5);
        run_frame("R3 R5 R6 mode3 alt tpid", 3'd1, 12'h123, 18, 1, 32'h88A8_0123, -1);
        run_frame("R3 mode3 vid equals port vid", 3'd1, 12'd5, 16, 1, 32'h88A8_0005, -1);
        write_cfg(3'd2, 2'd1, 1'b0, 12'd100);
        run_frame("R4 mode1 native vid", 3'd2, 12'd100, 20, 0, 32'h0, -1);
        run_frame("R4 R5 mode1 other vid", 3'd2, 12'd7, 20, 1, 32'h8100_0007, -1);
        run_frame("R6 tag then one byte", 3'd2, 12'hFFE, 13, 1, 32'h8100_0FFE, -1);
    endtask

    task automatic t_runt;
        write_cfg(3'd3, 2'd3, 1'b0, 12'd0);
        run_frame("R8 12-byte frame", 3'd3, 12'd1, 12, 0, 32'h0, -1);
        run_frame("R8 5-byte frame", 3'd3, 12'd1, 5, 0, 32'h0, -1);
    endtask

    task automatic t_latch;
        write_cfg(3'd4, 2'd3, 1'b0, 12'd0);
        run_frame("R9 cfg change mid-frame", 3'd4, 12'd44, 20, 1, 32'h8100_002C, 3);
        run_frame("R9 next frame sees new cfg", 3'd4, 12'd44, 20, 0, 32'h0, -1);
    endtask

    task automatic t_cfg_write;
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 3'd6; cfg_mode = 2'd3; cfg_tpid_sel = 1'b1; cfg_vid = 12'd0;
        in_port = 3'd6; in_vid = 12'd77;
        #1 check("R10 not before clock", 64'(dec_insert), 64'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 after clock", 64'({dec_insert, dec_tag}), 64'h1_88A8_004D);
        in_port = 3'd5;
        #1 check("R10 other port untouched", 64'(dec_insert), 64'd0);
        in_port = 3'd2; in_vid = 12'd100;
        #1 check("R4 decision native", 64'(dec_insert), 64'd0);
        in_vid = 12'd101;
        #1 check("R4 R5 decision other", 64'({dec_insert, dec_tag}), 64'h1_8100_0065);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_latency();
        t_modes();
        t_runt();
        t_latch();
        t_cfg_write();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule